// File: doc/BRIEF.md
# Write-Protection Unlock Guard

This block sits between the host write strobes and a sector load controller. Every host write arrives as a one-cycle strobe with an address and a data word. The guard decides whether the write reaches the loader (`load_ok`), is turned away (`dummy_wr`), or is taken in as part of a command code. A turned-away write still asks the sector controller to run its internal write timer, so status polling behaves normally, but no array data changes. The protection flag is non-volatile. The ordinary reset does not clear it. Only the separate `nv_clr_n` input, which models the factory state, clears it.

Protection is switched on by a three-write unlock code. While it is on, the same three writes must open every program cycle. After the third write, a load window stays open for as long as each following write comes within `GAP_CYC` cycles of the previous one. A separate six-write code switches protection off. A write that does not match the code position expected next returns the matcher to idle. After reset, writes are ignored for `LOCK_CYC` cycles. They are also ignored whenever `supply_low` is high.

The state machine has four states:
- ST_LOCK: power-on lockout. It moves to ST_IDLE when the lockout count completes.
- ST_IDLE: waiting. A matching write moves to ST_SEQ. A plain write is permitted or rejected here, and the state stays put.
- ST_SEQ: a code prefix has been taken in. A match moves one position forward. The third unlock write moves to ST_LOAD. The sixth disable write returns to ST_IDLE. A mismatch or a gap timeout returns to ST_IDLE.
- ST_LOAD: the load window. Each write is permitted. A gap timeout returns to ST_IDLE.

Top module: `wp_guard`

## Requirements
- R1: `nv_clr_n` low clears `prot_on` to 0. A cycle of `rst_n` alone leaves `prot_on` unchanged.
- R2: A write strobed while fewer than `LOCK_CYC` cycles have passed since `rst_n` released gives neither `load_ok` nor `dummy_wr`.
- R3: A write strobed with `supply_low` high gives no output pulse. It also leaves both the flag and any code prefix in progress unchanged.
- R4: While `prot_on` is 0, a write that does not match the first code position gives `load_ok` one cycle after its strobe.
- R5: The unlock code, in position order 0, 1, 2, sets `prot_on` to 1 and opens the load window. The code is (0x1234, 0x00C3), (0x0ABC, 0x003C), (0x1234, 0x00E1) by default. Code writes give no pulse.
- R6: While `prot_on` is 1 and no load window is open, a write that is not a code write gives `dummy_wr` and not `load_ok`.
- R7: In the load window, a write whose strobe comes at most `GAP_CYC` cycles after the previous write gives `load_ok`. A longer gap closes the window.
- R8: The six-write disable code clears `prot_on` to 0, and later writes are permitted. The code is (0x1234, 0x00C3), (0x0ABC, 0x003C), (0x1234, 0x00D2), (0x1234, 0x00C3), (0x0ABC, 0x003C), (0x1234, 0x0087) by default.
- R9: A write that mismatches the expected code position returns the matcher to idle, and `prot_on` does not change. That write is permitted if unprotected and rejected if protected.
- R10: A gap of more than `GAP_CYC` cycles between two code writes abandons the code.
- R11: `load_ok` and `dummy_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the state machine and timers |
| nv_clr_n | input | 1 | Active-low factory clear of the protection flag |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| supply_low | input | 1 | Supply below the write threshold |
| load_ok | output | 1 | Pulse: pass this write to the sector loader |
| dummy_wr | output | 1 | Pulse: rejected write, run the write timer without storing |
| prot_on | output | 1 | Current protection flag |

## Verification
The bench sweeps the gap between the first and second data writes of a load window from 1 to `GAP_CYC`+2 cycles. A timer that was off by one would keep the window open one cycle too long or close it one cycle too early. It also corrupts each position of the unlock code and of the disable code in turn. A matcher that skipped a position, or that kept a partial prefix after a mismatch, would unlock or clear the flag when it should not. Further checks insert a low-supply write inside the code, cycle `rst_n` while protected, and clear the flag through the factory input. A design that let low-supply writes reset the matcher, or let the normal reset clear the flag, fails these checks.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [1:0] {
        ST_LOCK,
        ST_IDLE,
        ST_SEQ,
        ST_LOAD
    } wp_state_e;

    localparam int POS_W = 3;
    localparam logic [POS_W-1:0] UNL_LAST = 3'd2;
    localparam logic [POS_W-1:0] DIS_LAST = 3'd5;
endpackage

// File: rtl/wp_lockout.sv
module wp_lockout #(
    parameter int LOCK_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int LW = $clog2(LOCK_CYC + 1);

    logic [LW-1:0] cnt_q;

    assign done = (cnt_q == LW'(LOCK_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!done)
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: once the lockout completes it stays complete until the next reset
    a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
endmodule

// File: rtl/wp_gap_timer.sv
module wp_gap_timer #(
    parameter int GAP_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic restart,
    output logic expire
);
    localparam int CW = $clog2(GAP_CYC + 1);

    logic [CW-1:0] cnt_q;

    assign expire = armed && !restart && (cnt_q == CW'(GAP_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || !armed)
            cnt_q <= '0;
        else if (!expire)
            cnt_q <= cnt_q + 1'b1;
    end

    // R7: the gap count never passes the window length
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(GAP_CYC));
endmodule

// File: rtl/wp_cmd_match.sv
module wp_cmd_match
    import wp_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter logic [3*AW-1:0] UNL_ADDR = '0,
    parameter logic [3*DW-1:0] UNL_DATA = '0,
    parameter logic [6*AW-1:0] DIS_ADDR = '0,
    parameter logic [6*DW-1:0] DIS_DATA = '0
) (
    input  logic [POS_W-1:0] pos,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    data,
    output logic             u_eq,
    output logic             d_eq
);
    logic [3:0] u_vec;
    logic [7:0] d_vec;

    genvar i;
    generate
        for (i = 0; i < 3; i++) begin : g_unl
            assign u_vec[i] = (addr == UNL_ADDR[i*AW +: AW]) &&
                              (data == UNL_DATA[i*DW +: DW]);
        end
        for (i = 0; i < 6; i++) begin : g_dis
            assign d_vec[i] = (addr == DIS_ADDR[i*AW +: AW]) &&
                              (data == DIS_DATA[i*DW +: DW]);
        end
    endgenerate

    assign u_vec[3]   = 1'b0;
    assign d_vec[7:6] = 2'b00;

    assign u_eq = (pos <= UNL_LAST) && u_vec[pos[1:0]];
    assign d_eq = d_vec[pos];
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int GAP_CYC  = 64,
    parameter int LOCK_CYC = 1000,
    parameter logic [3*AW-1:0] UNL_ADDR = {16'h1234, 16'h0ABC, 16'h1234},
    parameter logic [3*DW-1:0] UNL_DATA = {16'h00E1, 16'h003C, 16'h00C3},
    parameter logic [6*AW-1:0] DIS_ADDR = {16'h1234, 16'h0ABC, 16'h1234,
                                           16'h1234, 16'h0ABC, 16'h1234},
    parameter logic [6*DW-1:0] DIS_DATA = {16'h0087, 16'h003C, 16'h00C3,
                                           16'h00D2, 16'h003C, 16'h00C3}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nv_clr_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          supply_low,
    output logic          load_ok,
    output logic          dummy_wr,
    output logic          prot_on
);
    wp_state_e        state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d, cur_pos;
    logic             ua_q, ua_d, da_q, da_d;
    logic             prot_q, prot_d;
    logic             ok_d, dm_d;
    logic             lock_done, gap_exp, restart, armed;
    logic             u_eq, d_eq, u_m, d_m, wr_live, in_seq;

    wp_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .done(lock_done)
    );

    wp_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk(clk), .rst_n(rst_n), .armed(armed), .restart(restart), .expire(gap_exp)
    );

    wp_cmd_match #(
        .AW(AW), .DW(DW),
        .UNL_ADDR(UNL_ADDR), .UNL_DATA(UNL_DATA),
        .DIS_ADDR(DIS_ADDR), .DIS_DATA(DIS_DATA)
    ) u_match (
        .pos(cur_pos), .addr(wr_addr), .data(wr_data), .u_eq(u_eq), .d_eq(d_eq)
    );

    assign wr_live = wr_stb && !supply_low;
    assign in_seq  = (state_q == ST_SEQ);
    assign cur_pos = in_seq ? pos_q : '0;
    assign u_m     = (in_seq ? ua_q : 1'b1) && u_eq;
    assign d_m     = (in_seq ? da_q : 1'b1) && d_eq;
    assign armed   = (state_q == ST_SEQ) || (state_q == ST_LOAD);
    assign prot_on = prot_q;

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        ua_d    = ua_q;
        da_d    = da_q;
        prot_d  = prot_q;
        ok_d    = 1'b0;
        dm_d    = 1'b0;
        restart = 1'b0;
        unique case (state_q)
            ST_LOCK: begin
                if (lock_done)
                    state_d = ST_IDLE;
            end
            ST_IDLE, ST_SEQ: begin
                if (wr_live) begin
                    if (u_m && cur_pos == UNL_LAST) begin
                        prot_d  = 1'b1;
                        state_d = ST_LOAD;
                        restart = 1'b1;
                    end else if (d_m && cur_pos == DIS_LAST) begin
                        prot_d  = 1'b0;
                        state_d = ST_IDLE;
                    end else if (u_m || d_m) begin
                        state_d = ST_SEQ;
                        pos_d   = cur_pos + 1'b1;
                        ua_d    = u_m;
                        da_d    = d_m;
                        restart = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                        ok_d    = !prot_q;
                        dm_d    = prot_q;
                    end
                end else if (in_seq && gap_exp) begin
                    state_d = ST_IDLE;
                end
            end
            ST_LOAD: begin
                if (wr_live) begin
                    ok_d    = 1'b1;
                    restart = 1'b1;
                end else if (gap_exp) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCK;
            pos_q   <= '0;
            ua_q    <= 1'b0;
            da_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            ua_q    <= ua_d;
            da_q    <= da_d;
        end
    end

    // non-volatile flag: only the factory clear resets it
    always_ff @(posedge clk or negedge nv_clr_n) begin
        if (!nv_clr_n)
            prot_q <= 1'b0;
        else
            prot_q <= prot_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_ok  <= 1'b0;
            dummy_wr <= 1'b0;
        end else begin
            load_ok  <= ok_d;
            dummy_wr <= dm_d;
        end
    end

    // R1: the flag moves only on a live host write
    a_r1_flag_on_write: assert property (@(posedge clk) disable iff (!rst_n || !nv_clr_n)
        !$stable(prot_q) |-> $past(wr_stb && !supply_low));
    // R2: nothing leaves the block during lockout
    a_r2_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK) |=> (!load_ok && !dummy_wr));
    // R3: low supply writes have no visible effect
    a_r3_low_supply: assert property (@(posedge clk) disable iff (!rst_n || !nv_clr_n)
        supply_low |=> (!load_ok && !dummy_wr && $stable(prot_q)));
    // R6: a protected idle guard never permits a write
    a_r6_no_permit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && prot_q && wr_stb) |=> !load_ok);
    // R11: permit and reject are exclusive
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_ok && dummy_wr));
endmodule

// File: tb/sim_wp_guard.sv
module sim_wp_guard;
    localparam int GAP  = 8;
    localparam int LOCK = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nv_clr_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        supply_low = 1'b0;
    logic        load_ok, dummy_wr, prot_on;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;
    logic gok, gdm;

    logic [15:0] ua [3] = '{16'h1234, 16'h0ABC, 16'h1234};
    logic [15:0] ud [3] = '{16'h00C3, 16'h003C, 16'h00E1};
    logic [15:0] da [6] = '{16'h1234, 16'h0ABC, 16'h1234, 16'h1234, 16'h0ABC, 16'h1234};
    logic [15:0] dd [6] = '{16'h00C3, 16'h003C, 16'h00D2, 16'h00C3, 16'h003C, 16'h0087};

    always #4 clk = ~clk;

    wp_guard #(.GAP_CYC(GAP), .LOCK_CYC(LOCK)) u0 (
        .clk(clk), .rst_n(rst_n), .nv_clr_n(nv_clr_n), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .supply_low(supply_low),
        .load_ok(load_ok), .dummy_wr(dummy_wr), .prot_on(prot_on)
    );

    // called at a falling edge; strobe sampled on the next rising edge
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        gok = load_ok; gdm = dummy_wr;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic eok, input logic edm);
        checks++;
        if (gok !== eok || gdm !== edm) begin
            fails++;
            $display("FAIL %s ok=%0b dm=%0b expected ok=%0b dm=%0b", req, gok, gdm, eok, edm);
        end
    endtask

    task automatic chk_prot(input string req, input logic e);
        checks++;
        if (prot_on !== e) begin
            fails++;
            $display("FAIL %s prot_on=%0b expected %0b", req, prot_on, e);
        end
    endtask

    task automatic unlock(input string req);
        for (int i = 0; i < 3; i++) begin
            wr(ua[i], ud[i]);
            chk(req, 1'b0, 1'b0);
        end
    endtask

    initial begin
        idle(3);
        gok = load_ok; gdm = dummy_wr;
        chk("R1 reset outputs", 1'b0, 1'b0);
        chk_prot("R1 factory state", 1'b0);
        rst_n = 1'b1; nv_clr_n = 1'b1;
        // R2: lockout
        wr(16'h0400, 16'h1111);
        chk("R2 lockout", 1'b0, 1'b0);
        idle(LOCK + 4);
        // R4: unprotected writes pass
        for (int i = 0; i < 4; i++) begin
            wr(16'h0400 + 16'(i), 16'(i * 37 + 5));
            chk("R4 unprotected", 1'b1, 1'b0);
            idle(2);
        end
        // R3: low supply
        supply_low = 1'b1;
        wr(16'h0410, 16'h2222);
        supply_low = 1'b0;
        chk("R3 low supply", 1'b0, 1'b0);
        // R5 with an R3 low-supply write inside the code
        wr(ua[0], ud[0]); chk("R5 cmd0", 1'b0, 1'b0);
        wr(ua[1], ud[1]); chk("R5 cmd1", 1'b0, 1'b0);
        supply_low = 1'b1;
        wr(16'h0420, 16'h3333); chk("R3 inside code", 1'b0, 1'b0);
        supply_low = 1'b0;
        wr(ua[2], ud[2]); chk("R5 cmd2", 1'b0, 1'b0);
        chk_prot("R5 enable", 1'b1);
        wr(16'h0430, 16'h4444); chk("R7 window write", 1'b1, 1'b0);
        idle(GAP);
        wr(16'h0431, 16'h4445); chk("R6 after window closed", 1'b0, 1'b1);
        // R7: gap sweep
        for (int g = 1; g <= GAP + 2; g++) begin
            idle(GAP + 2);
            unlock("R5 sweep");
            wr(16'h0500, 16'(g)); chk("R7 first load", 1'b1, 1'b0);
            idle(g - 1);
            wr(16'h0501, 16'(g));
            chk("R7 gap sweep", g <= GAP, g > GAP);
        end
        // R10: gap between code writes
        for (int n = GAP - 1; n <= GAP; n++) begin
            idle(GAP + 2);
            wr(ua[0], ud[0]); chk("R10 cmd0", 1'b0, 1'b0);
            idle(n);
            wr(ua[1], ud[1]);
            chk("R10 cmd1 gap", 1'b0, n >= GAP);
            if (n < GAP) begin
                wr(ua[2], ud[2]); chk("R10 cmd2", 1'b0, 1'b0);
                wr(16'h0600, 16'h0001); chk("R10 unlocked load", 1'b1, 1'b0);
            end
            chk_prot("R10 flag", 1'b1);
        end
        // R9: corrupt each unlock position
        for (int k = 0; k < 3; k++) begin
            idle(GAP + 2);
            for (int j = 0; j < k; j++) begin
                wr(ua[j], ud[j]); chk("R9 prefix", 1'b0, 1'b0);
            end
            wr(ua[k], ud[k] ^ 16'h0100); chk("R9 bad unlock", 1'b0, 1'b1);
            wr(16'h0700, 16'(k)); chk("R9 still locked", 1'b0, 1'b1);
        end
        // R9: corrupt each disable position
        for (int k = 0; k < 6; k++) begin
            idle(GAP + 2);
            for (int j = 0; j < k; j++) begin
                wr(da[j], dd[j]); chk("R9 dis prefix", 1'b0, 1'b0);
            end
            wr(da[k], dd[k] ^ 16'h0100); chk("R9 bad disable", 1'b0, 1'b1);
            chk_prot("R9 flag kept", 1'b1);
        end
        // R1: reset alone keeps the flag
        idle(GAP + 2);
        rst_n = 1'b0; idle(3); rst_n = 1'b1;
        idle(LOCK + 4);
        chk_prot("R1 survives reset", 1'b1);
        wr(16'h0800, 16'h5555); chk("R1 protected after reset", 1'b0, 1'b1);
        // R8: disable
        for (int j = 0; j < 6; j++) begin
            wr(da[j], dd[j]); chk("R8 disable cmd", 1'b0, 1'b0);
        end
        chk_prot("R8 disabled", 1'b0);
        wr(16'h0810, 16'h6666); chk("R8 write after disable", 1'b1, 1'b0);
        // R9: unprotected mismatch mid-code is permitted
        wr(ua[0], ud[0]); chk("R9 unprot cmd0", 1'b0, 1'b0);
        wr(16'h0820, 16'h7777); chk("R9 unprot mismatch", 1'b1, 1'b0);
        chk_prot("R9 unprot flag", 1'b0);
        // R1: factory clear
        idle(GAP + 2);
        unlock("R5 before factory clear");
        chk_prot("R5 enabled again", 1'b1);
        idle(GAP + 2);
        nv_clr_n = 1'b0; rst_n = 1'b0; idle(2);
        nv_clr_n = 1'b1; rst_n = 1'b1; idle(1);
        chk_prot("R1 factory clear", 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule